// File: doc/BRIEF.md
# Two-Level Address Translation Unit

This block translates 32-bit logical addresses into 36-bit physical addresses for one address stream, and checks the access rights of each request. Two small fully associative translation buffers are searched in the same cycle: one caches 4 KB pages and the other caches 4 MB pages. When neither holds the page, a hardwired walker reads the in-memory page table. First it reads the top-level entry. If that entry points to a lower table, it then reads the lower-level entry. The walker refills the matching buffer, and the held request is then looked up again.

A requester raises `req_valid` with the address and the access kind, and holds them until `rsp_valid` pulses for one cycle. Table reads go out one word at a time. `mem_req` and `mem_addr` stay steady until the memory returns `mem_ack` together with `mem_rdata`. A small configuration port sets the table base and the enable, and invalidates single pages. It also reads back the last faulting address and the fault code.

Page descriptors are 32 bits wide:
- bits 31:30 hold the kind: 00 invalid, 01 large page, 10 pointer to a lower table, 11 small page.
- bits 29 to 24 hold the flags cacheable, writable, executable, user, global and dirty, in that order.
- bits 23:0 hold the page number.

Top module: `xlat_unit`

## Requirements
- R1: After reset:
  - translation is disabled and no response or table read is pending.
  - reading select 0 (bad address), select 1 (fault code) and select 3 (enable) returns zero.
- R2: While the enable is clear, a request completes one cycle after it is presented, with no fault, no table read and a physical address of `{4'h0, vaddr}`.
- R3: A miss on a small page makes two reads.
  - The first read is at `{base, vaddr[31:22], 2'b00}` and returns kind 10. The second is at `{entry[23:0], vaddr[21:12], 2'b00}` and returns kind 11.
  - The result is `{page, vaddr[11:0]}`, and `rsp_cacheable` equals the cacheable flag.
- R4: A top-level entry of kind 01 maps a large page after a single read. The address is `{page[23:10], vaddr[21:0]}`.
- R5: A repeated access to a page already held completes one cycle after it is presented, with no table read. This holds for both page sizes.
- R6: Faults from invalid entries:
  - A top-level entry of kind 00 or 11 faults with code 1.
  - A lower-level entry of any kind other than 11 faults with code 2.
  - On any fault, `rsp_paddr` is zero and the faulting address is latched into the bad-address register.
- R7: Rights faults, in order of priority:
  - A user access to a page whose user flag is clear gives code 5.
  - Otherwise, a write to a page whose writable flag is clear gives code 3.
  - Otherwise, a fetch from a page whose executable flag is clear gives code 4.
- R8: A write to select 0 loads `wdata[23:0]` as the table base. It also drops every buffered page whose global flag is clear. Global pages remain held.
- R9: A write to select 2 invalidates the buffered page that covers `wdata`, in both buffers, whatever its global flag.
- R10: Refill replaces entries round robin. After 8 different small pages fill the 8-entry buffer, a ninth page evicts the oldest of them.
- R11: A table read request keeps `mem_req` high and `mem_addr` stable until `mem_ack`.
- R12: A write to select 1 sets the enable from `wdata[0]`, and select 3 reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, held until `rsp_valid` |
| req_vaddr | input | 32 | Logical address |
| req_write | input | 1 | Access is a store |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is made in user mode |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_paddr | output | 36 | Physical address, zero on fault |
| rsp_fault | output | 1 | Request faulted |
| rsp_cacheable | output | 1 | Cacheable flag of the page |
| mem_req | output | 1 | Table word read request |
| mem_addr | output | 36 | Byte address of the table word |
| mem_ack | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Table word read back |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wsel | input | 2 | Write select: 0 base, 1 enable, 2 invalidate |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rsel | input | 2 | Read select: 0 bad address, 1 code, 2 base, 3 enable |
| cfg_rdata | output | 32 | Configuration read data |

## Verification
The hardest situation to reach from the ports is the round-robin victim choice, because the replacement pointer is hidden and keeps advancing across all earlier fills. The stimulus first fills eight fresh pages in a row, so that every slot holds one of them whatever the pointer started at. It then brings in a ninth page and counts table reads to see which page was lost. Flush and invalidate are judged the same way, by whether a later access triggers a walk. Constrained random accesses are also run over a mixed table of large, small and invalid entries. This table has more small pages than the buffer holds, so eviction and refill interleave with the rights checks.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int VA_W  = 32;
   localparam int PA_W  = 36;
   localparam int PPN_W = 24;
   localparam int OFF_W = 12;
   localparam int LVL_W = 10;

   typedef struct packed {
      logic c;
      logic w;
      logic x;
      logic u;
      logic g;
      logic d;
   } pte_flags_t;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'b00,
      KIND_BIG   = 2'b01,
      KIND_PTR   = 2'b10,
      KIND_SMALL = 2'b11
   } pte_kind_t;

   localparam logic [2:0] FLT_NONE  = 3'd0;
   localparam logic [2:0] FLT_TOP   = 3'd1;
   localparam logic [2:0] FLT_LOW   = 3'd2;
   localparam logic [2:0] FLT_WRITE = 3'd3;
   localparam logic [2:0] FLT_EXEC  = 3'd4;
   localparam logic [2:0] FLT_USER  = 3'd5;

   localparam logic [1:0] WSEL_BASE  = 2'd0;
   localparam logic [1:0] WSEL_EN    = 2'd1;
   localparam logic [1:0] WSEL_INVAL = 2'd2;
   localparam logic [1:0] RSEL_BADVA = 2'd0;
   localparam logic [1:0] RSEL_CODE  = 2'd1;
   localparam logic [1:0] RSEL_BASE  = 2'd2;
   localparam logic [1:0] RSEL_EN    = 2'd3;
endpackage

// File: rtl/xlat_tlb_bank.sv
module xlat_tlb_bank
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   output pte_flags_t       lk_flags,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [PPN_W-1:0] fill_ppn,
   input  pte_flags_t       fill_flags,
   input  logic             flush_en,
   input  logic             inval_en,
   input  logic [TAG_W-1:0] inval_tag
);
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 1 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("xlat_tlb_bank: ENTRIES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("xlat_tlb_bank: TAG_W must be positive");
   end

   logic [ENTRIES-1:0] hit_vec;
   logic [PPN_W-1:0]   ppn_vec [ENTRIES];
   pte_flags_t         flg_vec [ENTRIES];
   logic [PTR_W-1:0]   rr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (fill_en) begin
         rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] tag_q;
      logic [PPN_W-1:0] ppn_q;
      pte_flags_t       flg_q;
      logic             pick;

      assign pick = fill_en && (rr_q == PTR_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
         end else if (pick) begin
            v_q <= 1'b1;
         end else if ((flush_en && !flg_q.g) || (inval_en && tag_q == inval_tag)) begin
            v_q <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (pick) begin
            tag_q <= fill_tag;
            ppn_q <= fill_ppn;
            flg_q <= fill_flags;
         end
      end

      assign hit_vec[e] = v_q && (tag_q == lk_tag);
      assign ppn_vec[e] = ppn_q;
      assign flg_vec[e] = flg_q;
   end

   always_comb begin
      lk_ppn   = '0;
      lk_flags = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            lk_ppn   = lk_ppn | ppn_vec[i];
            lk_flags = lk_flags | flg_vec[i];
         end
      end
   end

   assign lk_hit = |hit_vec;
endmodule

// File: rtl/xlat_rights.sv
module xlat_rights
   import xlat_pkg::*;
(
   input  logic       may_write,
   input  logic       may_exec,
   input  logic       may_user,
   input  logic       is_write,
   input  logic       is_exec,
   input  logic       is_user,
   output logic [2:0] code
);
   always_comb begin
      code = FLT_NONE;
      if (is_exec && !may_exec)   code = FLT_EXEC;
      if (is_write && !may_write) code = FLT_WRITE;
      if (is_user && !may_user)   code = FLT_USER;
   end
endmodule

// File: rtl/xlat_regs.sv
module xlat_regs
   import xlat_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_wsel,
   input  logic [31:0]      cfg_wdata,
   input  logic [1:0]       cfg_rsel,
   output logic [31:0]      cfg_rdata,
   input  logic             fault_set,
   input  logic [VA_W-1:0]  fault_va,
   input  logic [2:0]       fault_code,
   output logic [PPN_W-1:0] base_q,
   output logic             en_q,
   output logic [VA_W-1:0]  badva_q,
   output logic             flush_pulse,
   output logic             inval_pulse,
   output logic [VA_W-1:0]  inval_va
);
   logic [2:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         en_q    <= 1'b0;
         badva_q <= '0;
         code_q  <= FLT_NONE;
      end else begin
         if (cfg_we && cfg_wsel == WSEL_BASE) base_q <= cfg_wdata[PPN_W-1:0];
         if (cfg_we && cfg_wsel == WSEL_EN)   en_q   <= cfg_wdata[0];
         if (fault_set) begin
            badva_q <= fault_va;
            code_q  <= fault_code;
         end
      end
   end

   assign flush_pulse = cfg_we && (cfg_wsel == WSEL_BASE);
   assign inval_pulse = cfg_we && (cfg_wsel == WSEL_INVAL);
   assign inval_va    = cfg_wdata;

   always_comb begin
      unique case (cfg_rsel)
         RSEL_BADVA: cfg_rdata = badva_q;
         RSEL_CODE:  cfg_rdata = {29'd0, code_q};
         RSEL_BASE:  cfg_rdata = {{(32 - PPN_W){1'b0}}, base_q};
         default:    cfg_rdata = {31'd0, en_q};
      endcase
   end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
   import xlat_pkg::*;
#(
   parameter int SMALL_ENTRIES = 8,
   parameter int BIG_ENTRIES   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   input  logic             req_exec,
   input  logic             req_user,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_fault,
   output logic             rsp_cacheable,
   output logic             mem_req,
   output logic [PA_W-1:0]  mem_addr,
   input  logic             mem_ack,
   input  logic [31:0]      mem_rdata,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_wsel,
   input  logic [31:0]      cfg_wdata,
   input  logic [1:0]       cfg_rsel,
   output logic [31:0]      cfg_rdata
);
   localparam int SMALL_TAG_W = VA_W - OFF_W;
   localparam int BIG_TAG_W   = LVL_W;
   localparam int BIG_OFF_W   = VA_W - LVL_W;
   localparam int BIG_PFX_W   = PA_W - BIG_OFF_W;

   if (PA_W != PPN_W + OFF_W) begin : g_bad_pa
      $error("xlat_unit: physical width must equal page number plus offset");
   end

   typedef enum logic [1:0] {S_IDLE, S_TOP, S_LOW, S_RESP} walk_state_t;

   walk_state_t      state_q, state_nx;
   logic [PPN_W-1:0] low_base_q;
   logic [PA_W-1:0]  paddr_q;
   logic             fault_q, cach_q;

   logic [PPN_W-1:0] cfg_base;
   logic             cfg_en;
   logic [VA_W-1:0]  cfg_badva;
   logic             flush_pulse, inval_pulse;
   logic [VA_W-1:0]  inval_va;

   logic             big_hit, small_hit;
   logic [PPN_W-1:0] big_ppn, small_ppn;
   pte_flags_t       big_flags, small_flags, hit_flags;
   logic [2:0]       rights_code;

   pte_kind_t        rd_kind;
   pte_flags_t       rd_flags;
   logic [PPN_W-1:0] rd_ppn;

   logic             fill_big, fill_small;
   logic             done_ok, done_fault;
   logic [2:0]       done_code;
   logic [PA_W-1:0]  done_paddr;
   logic             done_cach;

   assign rd_kind  = pte_kind_t'(mem_rdata[31:30]);
   assign rd_flags = mem_rdata[29:24];
   assign rd_ppn   = mem_rdata[PPN_W-1:0];

   xlat_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wsel   (cfg_wsel),
      .cfg_wdata  (cfg_wdata),
      .cfg_rsel   (cfg_rsel),
      .cfg_rdata  (cfg_rdata),
      .fault_set  (done_fault),
      .fault_va   (req_vaddr),
      .fault_code (done_code),
      .base_q     (cfg_base),
      .en_q       (cfg_en),
      .badva_q    (cfg_badva),
      .flush_pulse(flush_pulse),
      .inval_pulse(inval_pulse),
      .inval_va   (inval_va)
   );

   xlat_tlb_bank #(.ENTRIES(BIG_ENTRIES), .TAG_W(BIG_TAG_W)) u_big (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_tag    (req_vaddr[VA_W-1 -: BIG_TAG_W]),
      .lk_hit    (big_hit),
      .lk_ppn    (big_ppn),
      .lk_flags  (big_flags),
      .fill_en   (fill_big),
      .fill_tag  (req_vaddr[VA_W-1 -: BIG_TAG_W]),
      .fill_ppn  (rd_ppn),
      .fill_flags(rd_flags),
      .flush_en  (flush_pulse),
      .inval_en  (inval_pulse),
      .inval_tag (inval_va[VA_W-1 -: BIG_TAG_W])
   );

   xlat_tlb_bank #(.ENTRIES(SMALL_ENTRIES), .TAG_W(SMALL_TAG_W)) u_small (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_tag    (req_vaddr[VA_W-1 -: SMALL_TAG_W]),
      .lk_hit    (small_hit),
      .lk_ppn    (small_ppn),
      .lk_flags  (small_flags),
      .fill_en   (fill_small),
      .fill_tag  (req_vaddr[VA_W-1 -: SMALL_TAG_W]),
      .fill_ppn  (rd_ppn),
      .fill_flags(rd_flags),
      .flush_en  (flush_pulse),
      .inval_en  (inval_pulse),
      .inval_tag (inval_va[VA_W-1 -: SMALL_TAG_W])
   );

   assign hit_flags = big_hit ? big_flags : small_flags;

   xlat_rights u_rights (
      .may_write(hit_flags.w),
      .may_exec (hit_flags.x),
      .may_user (hit_flags.u),
      .is_write (req_write),
      .is_exec  (req_exec),
      .is_user  (req_user),
      .code     (rights_code)
   );

   always_comb begin
      state_nx   = state_q;
      fill_big   = 1'b0;
      fill_small = 1'b0;
      done_ok    = 1'b0;
      done_fault = 1'b0;
      done_code  = FLT_NONE;
      done_paddr = '0;
      done_cach  = 1'b0;
      unique case (state_q)
         S_IDLE: if (req_valid) begin
            if (!cfg_en) begin
               done_ok    = 1'b1;
               done_paddr = {{(PA_W - VA_W){1'b0}}, req_vaddr};
               state_nx   = S_RESP;
            end else if (big_hit || small_hit) begin
               state_nx = S_RESP;
               if (rights_code != FLT_NONE) begin
                  done_fault = 1'b1;
                  done_code  = rights_code;
               end else begin
                  done_ok    = 1'b1;
                  done_cach  = hit_flags.c;
                  done_paddr = big_hit
                     ? {big_ppn[PPN_W-1 -: BIG_PFX_W], req_vaddr[BIG_OFF_W-1:0]}
                     : {small_ppn, req_vaddr[OFF_W-1:0]};
               end
            end else begin
               state_nx = S_TOP;
            end
         end
         S_TOP: if (mem_ack) begin
            if (rd_kind == KIND_BIG) begin
               fill_big = 1'b1;
               state_nx = S_IDLE;
            end else if (rd_kind == KIND_PTR) begin
               state_nx = S_LOW;
            end else begin
               done_fault = 1'b1;
               done_code  = FLT_TOP;
               state_nx   = S_RESP;
            end
         end
         S_LOW: if (mem_ack) begin
            if (rd_kind == KIND_SMALL) begin
               fill_small = 1'b1;
               state_nx   = S_IDLE;
            end else begin
               done_fault = 1'b1;
               done_code  = FLT_LOW;
               state_nx   = S_RESP;
            end
         end
         default: state_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         low_base_q <= '0;
         paddr_q    <= '0;
         fault_q    <= 1'b0;
         cach_q     <= 1'b0;
      end else begin
         state_q <= state_nx;
         if (state_q == S_TOP && mem_ack) low_base_q <= rd_ppn;
         if (done_ok || done_fault) begin
            paddr_q <= done_paddr;
            fault_q <= done_fault;
            cach_q  <= done_cach;
         end
      end
   end

   assign mem_req  = (state_q == S_TOP) || (state_q == S_LOW);
   assign mem_addr = (state_q == S_LOW)
      ? {low_base_q, req_vaddr[BIG_OFF_W-1 -: LVL_W], 2'b00}
      : {cfg_base, req_vaddr[VA_W-1 -: LVL_W], 2'b00};

   assign rsp_valid     = (state_q == S_RESP);
   assign rsp_paddr     = paddr_q;
   assign rsp_fault     = fault_q;
   assign rsp_cacheable = cach_q;
endmodule

// File: rtl/xlat_unit_sva.sv
module xlat_unit_sva
   import xlat_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic [VA_W-1:0] req_vaddr,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            rsp_fault,
   input logic            mem_req,
   input logic [PA_W-1:0] mem_addr,
   input logic            mem_ack,
   input logic            cfg_en,
   input logic [VA_W-1:0] cfg_badva
);
   a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req);

   a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> $stable(mem_addr));

   a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !cfg_en |-> !rsp_fault && rsp_paddr == {4'h0, req_vaddr});

   a_r6_badva_latched: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> cfg_badva == req_vaddr && rsp_paddr == '0);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !rsp_valid);
endmodule

bind xlat_unit xlat_unit_sva u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_vaddr(req_vaddr),
   .rsp_valid(rsp_valid),
   .rsp_paddr(rsp_paddr),
   .rsp_fault(rsp_fault),
   .mem_req  (mem_req),
   .mem_addr (mem_addr),
   .mem_ack  (mem_ack),
   .cfg_en   (cfg_en),
   .cfg_badva(cfg_badva)
);

// File: tb/tb_xlat_unit.sv
module tb_xlat_unit;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        req_valid, req_write, req_exec, req_user;
   logic [31:0] req_vaddr;
   logic        rsp_valid, rsp_fault, rsp_cacheable;
   logic [35:0] rsp_paddr;
   logic        mem_req, mem_ack;
   logic [35:0] mem_addr;
   logic [31:0] mem_rdata;
   logic        cfg_we;
   logic [1:0]  cfg_wsel, cfg_rsel;
   logic [31:0] cfg_wdata, cfg_rdata;

   xlat_unit dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
      .req_exec(req_exec), .req_user(req_user),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .rsp_cacheable(rsp_cacheable),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .cfg_we(cfg_we), .cfg_wsel(cfg_wsel), .cfg_wdata(cfg_wdata),
      .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int mem_reads = 0;
   logic [35:0] rd_log [4];
   logic [31:0] ptab [logic [35:0]];

   localparam logic [23:0] BASE = 24'h000010;
   localparam logic [5:0] F_C = 6'b100000, F_W = 6'b010000, F_X = 6'b001000,
                          F_U = 6'b000100, F_G = 6'b000010;
   localparam logic [5:0] F_ALL = F_C | F_W | F_X | F_U;

   function automatic logic [31:0] mk(logic [1:0] kind, logic [5:0] fl, logic [23:0] ppn);
      return {kind, fl, ppn};
   endfunction

   function automatic logic [31:0] rd(logic [35:0] a);
      if (ptab.exists(a)) return ptab[a];
      return 32'h0;
   endfunction

   function automatic logic [31:0] va_of(int top, int low, logic [11:0] off);
      return {top[9:0], low[9:0], off};
   endfunction

   function automatic void ref_xlat(input logic [31:0] va, input logic wr, ex, us,
                                    output logic [35:0] pa, output logic [2:0] code,
                                    output logic cach);
      logic [31:0] d1, d2;
      logic [5:0]  fl;
      pa = '0; code = 3'd0; cach = 1'b0; fl = '0;
      d1 = rd({BASE, va[31:22], 2'b00});
      if (d1[31:30] == 2'b01) begin
         fl = d1[29:24]; pa = {d1[23:10], va[21:0]};
      end else if (d1[31:30] == 2'b10) begin
         d2 = rd({d1[23:0], va[21:12], 2'b00});
         if (d2[31:30] != 2'b11) begin code = 3'd2; return; end
         fl = d2[29:24]; pa = {d2[23:0], va[11:0]};
      end else begin
         code = 3'd1; return;
      end
      if (us && !fl[2])      code = 3'd5;
      else if (wr && !fl[4]) code = 3'd3;
      else if (ex && !fl[3]) code = 3'd4;
      if (code != 3'd0) pa = '0;
      else cach = fl[5];
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // memory responder
   initial begin
      mem_ack = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req && rst_n) begin
            repeat ($urandom % 3) @(negedge clk);
            mem_rdata = rd(mem_addr);
            rd_log[mem_reads % 4] = mem_addr;
            mem_reads++;
            mem_ack = 1'b1;
         end
      end
   end

   task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wsel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [1:0] s, output logic [31:0] v);
      cfg_rsel = s;
      #1;
      v = cfg_rdata;
   endtask

   task automatic access(input logic [31:0] va, input logic wr, ex, us,
                         output logic [35:0] pa, output logic flt, output logic cach,
                         output int lat, output int nrd);
      int r0;
      @(negedge clk);
      r0 = mem_reads;
      req_vaddr = va; req_write = wr; req_exec = ex; req_user = us;
      req_valid = 1'b1;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!rsp_valid && lat < 2000);
      pa = rsp_paddr; flt = rsp_fault; cach = rsp_cacheable;
      req_valid = 1'b0;
      nrd = mem_reads - r0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [35:0] pa, epa;
      logic        flt, cach, ecach;
      logic [2:0]  ecode;
      logic [31:0] v;
      int          lat, nrd;
      logic [31:0] va;

      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_exec = 1'b0; req_user = 1'b0;
      cfg_we = 1'b0; cfg_wsel = '0; cfg_wdata = '0; cfg_rsel = '0;

      // directed table
      ptab[{BASE, 10'd32, 2'b00}] = mk(2'b10, 6'b0, 24'h000200);
      ptab[{24'h000200, 10'd0, 2'b00}]  = mk(2'b11, F_ALL, 24'h123456);
      ptab[{24'h000200, 10'd1, 2'b00}]  = mk(2'b11, F_ALL | F_G, 24'h0ABCDE);
      ptab[{24'h000200, 10'd2, 2'b00}]  = mk(2'b00, F_ALL, 24'h000001);
      ptab[{24'h000200, 10'd3, 2'b00}]  = mk(2'b11, F_C, 24'h000777);
      for (int i = 16; i < 25; i++)
         ptab[{24'h000200, i[9:0], 2'b00}] = mk(2'b11, F_ALL, 24'h100000 + 24'(i));
      ptab[{BASE, 10'd33, 2'b00}] = mk(2'b01, F_ALL, 24'hABC400);
      ptab[{BASE, 10'd34, 2'b00}] = mk(2'b00, F_ALL, 24'h000000);
      ptab[{BASE, 10'd35, 2'b00}] = mk(2'b11, F_ALL, 24'h000055);

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1 mem_req", 64'(mem_req), 64'd0);
      cfg_read(2'd0, v); chk("R1 badva", 64'(v), 64'd0);
      cfg_read(2'd1, v); chk("R1 code", 64'(v), 64'd0);
      cfg_read(2'd3, v); chk("R1 enable", 64'(v), 64'd0);
      rst_n = 1'b1;

      // R2: pass-through while disabled
      access(32'hDEADBEEF, 1'b1, 1'b0, 1'b1, pa, flt, cach, lat, nrd);
      chk("R2 paddr", 64'(pa), 64'h0_DEAD_BEEF);
      chk("R2 fault/lat/reads", {flt, 8'(lat), 8'(nrd)}, {1'b0, 8'd1, 8'd0});

      // R12 / R8: enable and base
      cfg_write(2'd0, {8'h0, BASE});
      cfg_write(2'd1, 32'd1);
      cfg_read(2'd3, v); chk("R12 enable readback", 64'(v), 64'd1);
      cfg_read(2'd2, v); chk("R8 base readback", 64'(v), 64'(BASE));

      // R3: small page walk
      va = va_of(32, 0, 12'hABC);
      access(va, 1'b0, 1'b0, 1'b1, pa, flt, cach, lat, nrd);
      chk("R3 paddr", 64'(pa), 64'h1_2345_6ABC);
      chk("R3 fault/cach/reads", {flt, cach, 8'(nrd)}, {1'b0, 1'b1, 8'd2});
      chk("R3 top addr", 64'(rd_log[(mem_reads - 2) % 4]), 64'({BASE, 10'd32, 2'b00}));
      chk("R3 low addr", 64'(rd_log[(mem_reads - 1) % 4]), 64'({24'h000200, 10'd0, 2'b00}));
      // R5: small hit
      access(va, 1'b1, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      chk("R5 small hit", {pa, flt, 8'(lat), 8'(nrd)}, {36'h1_2345_6ABC, 1'b0, 8'd1, 8'd0});

      // R4: large page
      va = va_of(33, 5, 12'h123);
      access(va, 1'b0, 1'b1, 1'b0, pa, flt, cach, lat, nrd);
      chk("R4 paddr", 64'(pa), 64'({14'h2AF1, va[21:0]}));
      chk("R4 reads", {flt, 8'(nrd)}, {1'b0, 8'd1});
      access(va_of(33, 900, 12'h7), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      chk("R5 big hit", {pa, 8'(lat), 8'(nrd)}, {14'h2AF1, 10'd900, 12'h7, 8'd1, 8'd0});

      // R6: invalid entries
      va = va_of(34, 1, 12'h10);
      access(va, 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      cfg_read(2'd1, v);
      chk("R6 top kind 00", {pa, flt, v[2:0]}, {36'h0, 1'b1, 3'd1});
      cfg_read(2'd0, v); chk("R6 badva", 64'(v), 64'(va));
      access(va_of(35, 0, 12'h0), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      cfg_read(2'd1, v);
      chk("R6 top kind 11", {flt, v[2:0]}, {1'b1, 3'd1});
      va = va_of(32, 2, 12'h44);
      access(va, 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      cfg_read(2'd1, v);
      chk("R6 low invalid", {pa, flt, v[2:0], 8'(nrd)}, {36'h0, 1'b1, 3'd2, 8'd2});
      cfg_read(2'd0, v); chk("R6 badva low", 64'(v), 64'(va));

      // R7: rights on a page with W, X, U clear
      va = va_of(32, 3, 12'h8);
      access(va, 1'b1, 1'b1, 1'b1, pa, flt, cach, lat, nrd);
      cfg_read(2'd1, v); chk("R7 user first", {flt, v[2:0]}, {1'b1, 3'd5});
      access(va, 1'b1, 1'b1, 1'b0, pa, flt, cach, lat, nrd);
      cfg_read(2'd1, v); chk("R7 write next", {flt, v[2:0]}, {1'b1, 3'd3});
      access(va, 1'b0, 1'b1, 1'b0, pa, flt, cach, lat, nrd);
      cfg_read(2'd1, v); chk("R7 exec", {flt, v[2:0]}, {1'b1, 3'd4});
      access(va, 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      chk("R7 plain read ok", {pa, flt, cach}, {36'h0_0077_7008, 1'b0, 1'b1});

      // R8: flush keeps global pages
      access(va_of(32, 1, 12'h0), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      access(va_of(32, 0, 12'h0), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      cfg_write(2'd0, {8'h0, BASE});
      access(va_of(32, 1, 12'h4), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      chk("R8 global kept", {pa, 8'(nrd)}, {36'h0_ABCD_E004, 8'd0});
      access(va_of(32, 0, 12'h4), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      chk("R8 local dropped", 64'(nrd), 64'd2);
      access(va_of(33, 0, 12'h4), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      chk("R8 large dropped", 64'(nrd), 64'd1);

      // R9: invalidate by address
      cfg_write(2'd2, va_of(32, 1, 12'hFFF));
      access(va_of(32, 1, 12'h0), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      chk("R9 global small inval", 64'(nrd), 64'd2);
      cfg_write(2'd2, va_of(33, 77, 12'h0));
      access(va_of(33, 1, 12'h0), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      chk("R9 large inval", 64'(nrd), 64'd1);

      // R10: round robin
      for (int i = 16; i < 25; i++)
         access(va_of(32, i, 12'h0), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      begin
         int tot = 0;
         for (int i = 17; i < 24; i++) begin
            access(va_of(32, i, 12'h0), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
            tot += nrd;
         end
         chk("R10 newer pages held", 64'(tot), 64'd0);
      end
      access(va_of(32, 16, 12'h0), 1'b0, 1'b0, 1'b0, pa, flt, cach, lat, nrd);
      chk("R10 oldest evicted", {pa, 8'(nrd)}, {36'h1_0001_0000, 8'd2});

      // random table
      for (int t = 1; t <= 4; t++)
         ptab[{BASE, t[9:0], 2'b00}] = mk(2'b01, 6'($urandom), 24'($urandom));
      ptab[{BASE, 10'd5, 2'b00}] = mk(2'b10, 6'b0, 24'h000300);
      for (int l = 0; l < 16; l++)
         ptab[{24'h000300, l[9:0], 2'b00}] =
            mk(($urandom % 5 == 0) ? 2'b00 : 2'b11, 6'($urandom) & ~F_G, 24'($urandom));
      ptab[{BASE, 10'd6, 2'b00}] = mk(2'b00, 6'b0, 24'h0);
      ptab[{BASE, 10'd7, 2'b00}] = mk(2'b11, F_ALL, 24'h0);

      for (int n = 0; n < 300; n++) begin
         logic wr, ex, us;
         va = va_of(1 + int'($urandom % 7), int'($urandom % 16), 12'($urandom));
         wr = 1'($urandom); ex = 1'($urandom); us = 1'($urandom);
         ref_xlat(va, wr, ex, us, epa, ecode, ecach);
         access(va, wr, ex, us, pa, flt, cach, lat, nrd);
         chk("R3/R4/R7 random result", {pa, flt, cach}, {epa, ecode != 3'd0, ecach});
         if (ecode != 3'd0) begin
            cfg_read(2'd1, v);
            chk("R6/R7 random code", 64'(v), 64'(ecode));
         end
      end

      finish_run();
   end
endmodule